// File: doc/BRIEF.md
# Sample Memory Access Controller

This block runs single 16-bit accesses to as many as three external memory devices, each on its own active-low chip strobe. Select 0 always holds a static ROM. Selects 1 and 2 hold either static parts (ROM or SRAM) or DRAM, depending on a board strap. When they hold DRAM, a second two-bit strap gives the device size, and that size sets how the word address is split into row and column halves on the shared address lines.

A requester places a word address, a device select, a read/write flag, byte enables and write data on the request port. The request is taken when `req_ready` is high. The controller then plays a fixed six-phase sequence on the memory pins. The clock `clk` is the phase clock, which runs at twice the master memory clock, so one access equals three master cycles. A read returns its data as a one-cycle pulse on the response port. A new request may be accepted in the last phase of the previous access, so accesses can follow each other with no gap.

The DRAM banks never need their own refresh slots. Whenever the ROM on select 0 is accessed while the DRAM strap is high, the controller lowers the DRAM CAS lines ahead of RAS in the same access, which performs a CAS-before-RAS refresh of every bank while the ROM read proceeds.

Top module: `sample_mem_ctrl`

## Requirements
- R1: While reset is held and after its release with no request, `mem_ras_n`, all `mem_cas_n` and both `mem_we_n` are high, `mem_wdata_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: An accepted request occupies exactly six `clk` cycles, phases 0 to 5, starting in the cycle after acceptance. `req_ready` is low in phases 0 to 4 and high in phase 5, so back-to-back requests start every six cycles.
- R3: For a static access (select 0, or select 1/2 with the strap low), `mem_addr` carries the full word address in all six phases. The chip strobe `mem_cas_n[sel]` is low in phases 1 to 4 and high in phases 0 and 5.
- R4: For a DRAM access (select 1/2 with the strap high), `mem_ras_n` is low in phases 1 to 4. `mem_cas_n[sel]` is low in phases 3 to 4. No other CAS line falls.
- R5: The size code d (0..3) gives n = 8 + d column bits. The row is `addr[2n-1:n]` and the column is `addr[n-1:0]`. `mem_addr` shows the row in phases 0 to 1 and the column in phases 2 to 5, with every bit above n zero.
- R6: For a ROM access on select 0 with the strap high, `mem_cas_n[1]` and `mem_cas_n[2]` are low in phases 2 to 4, and `mem_ras_n` is low in phases 3 to 4.
- R7: With the memory-type strap low, `mem_ras_n` stays high through every access.
- R8: On a write, `mem_wdata_oe` is high in all six phases and `mem_wdata` equals the request data. `mem_we_n[1]` (bits 15..8) and `mem_we_n[0]` (bits 7..0) are low only where the matching byte enable is 1: in phases 1 to 4 for static devices and in phases 2 to 4 for DRAM. On reads both stay high.
- R9: A read captures `mem_rdata` at the clock edge that ends phase 4. It presents that value on `rsp_rdata` with `rsp_valid` high for phase 5 only. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the master memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_dram | input | 1 | 1: selects 1 and 2 are DRAM; 0: static |
| strap_dsize | input | 2 | DRAM size code 0..3 (64K, 256K, 1M, 4M words) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_sel | input | 2 | Device select 0..2 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| req_addr | input | 22 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 22 | Memory address lines (word) |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 3 | Column strobes / chip selects, active low |
| mem_we_n | output | 2 | Byte write enables, active low |
| mem_wdata | output | 16 | Write data to memory |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | 16 | Read data from memory |

## Verification
The bench builds the block with its default parameters: a 22-bit word address, eight base column bits and three selects. With these values the widest DRAM size splits the address into two full 11-bit halves, and every size code sets a different row/column boundary that the bench reaches. Each access is followed phase by phase against a model computed from the strap settings. Accesses are issued back to back, so the phase-5 acceptance is always exercised. Read data is only valid on the memory bus during phase 4, which proves the capture point.

// File: rtl/sample_mem_pkg.sv
package sample_mem_pkg;

  // Phase plan of one access (phase clock = 2x master clock)
  localparam int unsigned ACCESS_PHASES = 6;
  localparam int unsigned PH_STROBE_ON  = 1; // static strobe, DRAM RAS
  localparam int unsigned PH_COLUMN     = 2; // column address, refresh CAS
  localparam int unsigned PH_DCAS_ON    = 3; // DRAM CAS, refresh RAS
  localparam int unsigned PH_CAPTURE    = 4; // last strobe phase, read sample
  localparam int unsigned PH_LAST       = ACCESS_PHASES - 1;

  typedef struct packed {
    logic       ras_n;
    logic [2:0] cas_n;
    logic [1:0] we_n;
  } strobe_t;

endpackage

// File: rtl/smc_phase_seq.sv
module smc_phase_seq #(
  parameter int unsigned PHASES = 6,
  localparam int unsigned PH_W  = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  output logic            accept,
  output logic            busy_q,
  output logic [PH_W-1:0] phase_q,
  output logic            busy_d,
  output logic [PH_W-1:0] phase_d
);

  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  always_comb begin
    req_ready = !busy_q || (phase_q == LAST);
    accept    = req_valid && req_ready;
    busy_d    = busy_q;
    phase_d   = phase_q;
    if (accept) begin
      busy_d  = 1'b1;
      phase_d = '0;
    end else if (busy_q && phase_q == LAST) begin
      busy_d  = 1'b0;
      phase_d = '0;
    end else if (busy_q) begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/smc_addr_mux.sv
module smc_addr_mux #(
  parameter int unsigned AW       = 22,
  parameter int unsigned MUX_W    = 12,
  parameter int unsigned COL_BASE = 8,
  parameter int unsigned SIZE_W   = 2,
  localparam int unsigned NSIZE   = 1 << SIZE_W
) (
  input  logic [AW-1:0]     word_addr,
  input  logic [SIZE_W-1:0] size_code,
  input  logic              dram_cycle,
  input  logic              col_phase,
  output logic [AW-1:0]     addr_out
);

  logic [MUX_W-1:0] row_c [NSIZE];
  logic [MUX_W-1:0] col_c [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int unsigned NB = COL_BASE + s;
    assign col_c[s] = MUX_W'(word_addr[NB-1:0]);
    assign row_c[s] = MUX_W'(word_addr[2*NB-1:NB]);
  end

  always_comb begin
    if (dram_cycle) begin
      addr_out = AW'(col_phase ? col_c[size_code] : row_c[size_code]);
    end else begin
      addr_out = word_addr;
    end
  end

endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen
  import sample_mem_pkg::*;
#(
  parameter int unsigned PH_W = 3,
  parameter int unsigned NCS  = 3,
  parameter int unsigned BE_W = 2,
  localparam int unsigned SEL_W = $clog2(NCS + 1)
) (
  input  logic             active,
  input  logic [PH_W-1:0]  phase,
  input  logic [SEL_W-1:0] sel,
  input  logic             write,
  input  logic [BE_W-1:0]  be,
  input  logic             strap_dram,
  output logic             ras_n,
  output logic [NCS-1:0]   cas_n,
  output logic [BE_W-1:0]  we_n
);

  function automatic logic in_win(input int unsigned p, input int unsigned lo,
                                  input int unsigned hi);
    return (p >= lo) && (p <= hi);
  endfunction

  logic        is_dram;
  logic        refresh;
  int unsigned p;
  logic        own_win;
  logic        we_win;

  always_comb begin
    p       = int'(phase);
    is_dram = strap_dram && (sel != '0);
    refresh = strap_dram && (sel == '0);
    own_win = is_dram ? in_win(p, PH_DCAS_ON, PH_CAPTURE)
                      : in_win(p, PH_STROBE_ON, PH_CAPTURE);
    we_win  = is_dram ? in_win(p, PH_COLUMN, PH_CAPTURE)
                      : in_win(p, PH_STROBE_ON, PH_CAPTURE);
    ras_n   = !(active && ((is_dram && in_win(p, PH_STROBE_ON, PH_CAPTURE)) ||
                           (refresh && in_win(p, PH_DCAS_ON, PH_CAPTURE))));
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    logic own_hit;
    logic ref_hit;
    assign own_hit  = (sel == SEL_W'(i)) && own_win;
    assign ref_hit  = (i != 0) && refresh && in_win(p, PH_COLUMN, PH_CAPTURE);
    assign cas_n[i] = !(active && (own_hit || ref_hit));
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_be
    assign we_n[b] = !(active && write && be[b] && we_win);
  end

endmodule

// File: rtl/sample_mem_ctrl.sv
module sample_mem_ctrl
  import sample_mem_pkg::*;
#(
  parameter int unsigned AW       = 22,
  parameter int unsigned DW       = 16,
  parameter int unsigned NCS      = 3,
  parameter int unsigned MUX_W    = 12,
  parameter int unsigned COL_BASE = 8,
  parameter int unsigned SIZE_W   = 2,
  localparam int unsigned BE_W    = DW / 8,
  localparam int unsigned SEL_W   = $clog2(NCS + 1),
  localparam int unsigned PH_W    = $clog2(ACCESS_PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_dram,
  input  logic [SIZE_W-1:0] strap_dsize,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_ras_n,
  output logic [NCS-1:0]    mem_cas_n,
  output logic [BE_W-1:0]   mem_we_n,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_wdata_oe,
  input  logic [DW-1:0]     mem_rdata
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // sequencer
  logic            accept, busy_q, busy_d;
  logic [PH_W-1:0] phase_q, phase_d;

  smc_phase_seq #(.PHASES(ACCESS_PHASES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .accept   (accept),
    .busy_q   (busy_q),
    .phase_q  (phase_q),
    .busy_d   (busy_d),
    .phase_d  (phase_d)
  );

  // request hold registers
  logic [SEL_W-1:0] sel_q;
  logic             write_q;
  logic [BE_W-1:0]  be_q;
  logic [AW-1:0]    addr_hold_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q       <= '0;
      write_q     <= 1'b0;
      be_q        <= '0;
      addr_hold_q <= '0;
    end else if (accept) begin
      sel_q       <= req_sel;
      write_q     <= req_write;
      be_q        <= req_be;
      addr_hold_q <= req_addr;
    end
  end

  // request fields as seen in the next phase
  logic [SEL_W-1:0] sel_d;
  logic             write_d;
  logic [BE_W-1:0]  be_d;
  logic [AW-1:0]    addr_d;

  always_comb begin
    sel_d   = accept ? req_sel   : sel_q;
    write_d = accept ? req_write : write_q;
    be_d    = accept ? req_be    : be_q;
    addr_d  = accept ? req_addr  : addr_hold_q;
  end

  // strobes and address for the next phase
  logic            ras_d;
  logic [NCS-1:0]  cas_d;
  logic [BE_W-1:0] we_d;
  logic [AW-1:0]   mux_d;
  logic            dram_cycle_d;
  logic            col_phase_d;

  assign dram_cycle_d = strap_dram && (sel_d != '0);
  assign col_phase_d  = (int'(phase_d) >= PH_COLUMN);

  smc_strobe_gen #(.PH_W(PH_W), .NCS(NCS), .BE_W(BE_W)) u_strobe (
    .active    (busy_d),
    .phase     (phase_d),
    .sel       (sel_d),
    .write     (write_d),
    .be        (be_d),
    .strap_dram(strap_dram),
    .ras_n     (ras_d),
    .cas_n     (cas_d),
    .we_n      (we_d)
  );

  smc_addr_mux #(.AW(AW), .MUX_W(MUX_W), .COL_BASE(COL_BASE), .SIZE_W(SIZE_W)) u_mux (
    .word_addr (addr_d),
    .size_code (strap_dsize),
    .dram_cycle(dram_cycle_d),
    .col_phase (col_phase_d),
    .addr_out  (mux_d)
  );

  // registered pin drivers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mem_ras_n    <= 1'b1;
      mem_cas_n    <= '1;
      mem_we_n     <= '1;
      mem_wdata_oe <= 1'b0;
    end else begin
      mem_ras_n    <= ras_d;
      mem_cas_n    <= cas_d;
      mem_we_n     <= we_d;
      mem_wdata_oe <= busy_d && write_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  mem_addr <= '0;
    else if (busy_d) mem_addr <= mux_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  mem_wdata <= '0;
    else if (accept) mem_wdata <= req_wdata;
  end

  // read capture at the end of the last strobe phase
  logic capture_en;
  assign capture_en = busy_q && (int'(phase_q) == PH_CAPTURE) && !write_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)      rsp_rdata <= '0;
    else if (capture_en) rsp_rdata <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rsp_valid <= 1'b0;
    else            rsp_valid <= capture_en;
  end

endmodule

// File: rtl/sample_mem_ctrl_chk.sv
module sample_mem_ctrl_chk #(
  parameter int unsigned AW   = 22,
  parameter int unsigned NCS  = 3,
  parameter int unsigned BE_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            strap_dram,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_ras_n,
  input logic [NCS-1:0]  mem_cas_n,
  input logic [BE_W-1:0] mem_we_n,
  input logic            mem_wdata_oe
);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_SINGLE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9

  AST_WE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n != '1) |-> mem_wdata_oe); // R8

  AST_REFRESH_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ras_n && !mem_cas_n[0]) |-> (mem_cas_n[NCS-1:1] == '0)); // R6

  AST_ADDR_STABLE_AT_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(mem_cas_n) & ~mem_cas_n)) |-> $stable(mem_addr)); // R3

  AST_NO_RAS_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_dram |-> mem_ras_n); // R7

endmodule

bind sample_mem_ctrl sample_mem_ctrl_chk #(.AW(AW), .NCS(NCS), .BE_W(BE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .strap_dram  (strap_dram),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .mem_addr    (mem_addr),
  .mem_ras_n   (mem_ras_n),
  .mem_cas_n   (mem_cas_n),
  .mem_we_n    (mem_we_n),
  .mem_wdata_oe(mem_wdata_oe)
);

// File: tb/sample_mem_ctrl_tb_top.sv
module sample_mem_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        strap_dram;
  logic [1:0]  strap_dsize;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_sel;
  logic        req_write;
  logic [1:0]  req_be;
  logic [21:0] req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [21:0] mem_addr;
  logic        mem_ras_n;
  logic [2:0]  mem_cas_n;
  logic [1:0]  mem_we_n;
  logic [15:0] mem_wdata;
  logic        mem_wdata_oe;
  logic [15:0] mem_rdata;

  sample_mem_ctrl dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [21:0] addr;
    logic        ras_n;
    logic [2:0]  cas_n;
    logic [1:0]  we_n;
    logic        oe;
    logic [15:0] wd;
    logic        ready;
    logic        rv;
    logic [15:0] rd;
    bit          dram;
    bit          refr;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit win(input int k, input int lo, input int hi);
    return (k >= lo) && (k <= hi);
  endfunction

  function automatic exp_t model(input int k, input logic [1:0] sel, input bit wr,
                                 input logic [1:0] be, input logic [21:0] a,
                                 input logic [15:0] wd, input logic [15:0] rd);
    exp_t e;
    int   n;
    logic [21:0] mask;
    e.dram  = strap_dram && sel != 0;
    e.refr  = strap_dram && sel == 0;
    e.ras_n = 1'b1;
    e.cas_n = 3'b111;
    e.we_n  = 2'b11;
    if (e.dram) begin
      n    = 8 + int'(strap_dsize);
      mask = (22'd1 << n) - 22'd1;
      e.addr = (k < 2) ? ((a >> n) & mask) : (a & mask);
      if (win(k, 1, 4)) e.ras_n = 1'b0;
      if (win(k, 3, 4)) e.cas_n[sel] = 1'b0;
      if (wr && win(k, 2, 4)) e.we_n = ~be;
    end else begin
      e.addr = a;
      if (win(k, 1, 4)) e.cas_n[sel] = 1'b0;
      if (e.refr && win(k, 2, 4)) begin e.cas_n[1] = 1'b0; e.cas_n[2] = 1'b0; end
      if (e.refr && win(k, 3, 4)) e.ras_n = 1'b0;
      if (wr && win(k, 1, 4)) e.we_n = ~be;
    end
    e.oe    = wr;
    e.wd    = wd;
    e.ready = (k == 5);
    e.rv    = !wr && (k == 5);
    e.rd    = rd;
    return e;
  endfunction

  // driver: pushes expected phases, issues request, drives the memory data bus
  task automatic access(input logic [1:0] sel, input bit wr, input logic [1:0] be,
                        input logic [21:0] a, input logic [15:0] wd,
                        input logic [15:0] rd);
    for (int k = 0; k < 6; k++) exp_q.push_back(model(k, sel, wr, be, a, wd, rd));
    req_valid = 1'b1;
    req_sel   = sel;
    req_write = wr;
    req_be    = be;
    req_addr  = a;
    req_wdata = wd;
    @(posedge clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      mem_rdata = (k == 4) ? rd : ~rd;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: tracks phases from the handshake and compares against the queue
  initial begin
    bit   hs = 1'b0;
    bit   take;
    int   ph = -1;
    exp_t e;
    forever begin
      @(posedge clk);
      take = hs;
      #5;
      if (take) ph = 0;
      else if (ph >= 0 && ph < 5) ph++;
      else ph = -1;
      if (ph >= 0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected access", 0, 0);
        end else begin
          e = exp_q.pop_front();
          chk(mem_addr == e.addr, e.dram ? "R5" : "R3", "mem_addr", 32'(mem_addr), 32'(e.addr));
          chk(mem_ras_n == e.ras_n, e.dram ? "R4" : (e.refr ? "R6" : "R7"),
              "mem_ras_n", 32'(mem_ras_n), 32'(e.ras_n));
          chk(mem_cas_n == e.cas_n, e.dram ? "R4" : (e.refr ? "R6" : "R3"),
              "mem_cas_n", 32'(mem_cas_n), 32'(e.cas_n));
          chk(mem_we_n == e.we_n, "R8", "mem_we_n", 32'(mem_we_n), 32'(e.we_n));
          chk(mem_wdata_oe == e.oe, "R8", "mem_wdata_oe", 32'(mem_wdata_oe), 32'(e.oe));
          if (e.oe) chk(mem_wdata == e.wd, "R8", "mem_wdata", 32'(mem_wdata), 32'(e.wd));
          chk(req_ready == e.ready, "R2", "req_ready", 32'(req_ready), 32'(e.ready));
          chk(rsp_valid == e.rv, "R9", "rsp_valid", 32'(rsp_valid), 32'(e.rv));
          if (e.rv) chk(rsp_rdata == e.rd, "R9", "rsp_rdata", 32'(rsp_rdata), 32'(e.rd));
        end
      end
      @(negedge clk);
      #5;
      hs = req_valid && req_ready;
    end
  end

  task automatic check_idle(input string tag);
    chk(mem_ras_n === 1'b1, tag, "idle ras", 32'(mem_ras_n), 1);
    chk(mem_cas_n === 3'b111, tag, "idle cas", 32'(mem_cas_n), 7);
    chk(mem_we_n === 2'b11, tag, "idle we", 32'(mem_we_n), 3);
    chk(mem_wdata_oe === 1'b0, tag, "idle oe", 32'(mem_wdata_oe), 0);
    chk(rsp_valid === 1'b0, tag, "idle rsp_valid", 32'(rsp_valid), 0);
    chk(req_ready === 1'b1, tag, "idle ready", 32'(req_ready), 1);
  endtask

  initial begin
    rst_n       = 1'b0;
    strap_dram  = 1'b0;
    strap_dsize = 2'd0;
    req_valid   = 1'b0;
    req_sel     = '0;
    req_write   = 1'b0;
    req_be      = '0;
    req_addr    = '0;
    req_wdata   = '0;
    mem_rdata   = 16'h0000;
    idle(3);
    check_idle("R1");  // R1 during reset
    rst_n = 1'b1;
    idle(5);
    check_idle("R1");  // R1 after release

    // static mode: ROM and SRAM (R3, R7, R8, R9)
    access(2'd0, 1'b0, 2'b11, 22'h2A_5C3F, 16'h0000, 16'hBEEF);
    access(2'd1, 1'b1, 2'b11, 22'h15_0001, 16'h1234, 16'h0000);
    access(2'd2, 1'b1, 2'b01, 22'h3F_FFFF, 16'hA55A, 16'h0000);
    access(2'd2, 1'b0, 2'b11, 22'h00_0000, 16'h0000, 16'h8001);
    access(2'd1, 1'b1, 2'b10, 22'h0F_0F0F, 16'h5AA5, 16'h0000);
    idle(4);
    check_idle("R2");

    // DRAM mode at every size (R4, R5), refresh on ROM (R6)
    strap_dram = 1'b1;
    for (int d = 0; d < 4; d++) begin
      strap_dsize = 2'(d);
      idle(2);
      access(2'd1, 1'b0, 2'b11, 22'h3F_FFFF, 16'h0000, 16'(16'h1100 + d));
      access(2'd2, 1'b0, 2'b11, 22'h2A_AAAA, 16'h0000, 16'(16'h2200 + d));
      access(2'd0, 1'b0, 2'b11, 22'h12_3456, 16'h0000, 16'(16'h3300 + d));
      access(2'd2, 1'b1, 2'b10, 22'h15_5555, 16'(16'hC000 + d), 16'h0000);
      access(2'd1, 1'b1, 2'b01, 22'h01_0203, 16'(16'h0D00 + d), 16'h0000);
      idle(3);
    end
    idle(4);
    chk(exp_q.size() == 0, "R2", "pending expected phases", 32'(exp_q.size()), 0);
    check_idle("R1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule